// File: doc/BRIEF.md
# Multicore Doorbell Message Router

This block carries doorbell messages between the cores of a cluster. Every core has a send port and a clear port, each with a valid strobe and a 32-bit payload. A send payload holds a message kind, a broadcast flag and a 14-bit destination tag. A core is hit by the send when the broadcast flag is set, or when the tag equals that core's programmable identity register. Each hit core gets the pending bit that matches the kind, either normal or critical. Its interrupt-request line rises in the same cycle as that bit.

A clear from a core lowers only that core's own pending bit of the decoded kind. An acknowledge strobe from the core does the same when the core takes the doorbell. Guest kinds and undefined kinds are decoded and then dropped, so they change no state. When a set and a clear meet on the same core and kind in one cycle, the set wins. The pending bits feed the core's interrupt priority logic, which lies outside this block. That logic places the critical doorbell above the fixed-interval timer and the normal doorbell below the decrementer.

Top module: `db_router`

## Requirements
- R1: While reset is asserted and after it is released, with no message sent yet, every bit of `pend_norm`, `pend_crit` and `irq` is 0.
- R2: The kind field is payload bits [31:27]. Kind 0 is a normal doorbell and kind 1 is a critical doorbell. Kinds 2, 3 and 4 (guest, guest critical, guest machine-check) and kinds 5 to 31 change no pending bit, whether sent or used in a clear.
- R3: Without broadcast, a send of kind 0 or 1 sets the matching pending bit only in those cores whose identity register equals payload bits [13:0]. When no core matches, nothing changes.
- R4: Payload bit 26 set makes a send of kind 0 or 1 hit every core, whatever the tag.
- R5: `irq[c]` is 1 exactly when `pend_norm[c]` or `pend_crit[c]` is 1, in the same cycle.
- R6: A valid clear on core c's clear port lowers only `pend_norm[c]` (kind 0) or only `pend_crit[c]` (kind 1). The other kind and the other cores are left unchanged.
- R7: If a set and a clear or acknowledge reach the same core and kind in one cycle, the pending bit ends up 1.
- R8: `ack_norm[c]` lowers `pend_norm[c]` and `ack_crit[c]` lowers `pend_crit[c]`.
- R9: Core c's identity register resets to the value c. When `id_we[c]` is high, the register loads `id_wdata`, and sends in later cycles match against the new value.
- R10: Sends from several cores in the same cycle add up: every core hit by any of them gets its bit.
- R11: A send, clear or acknowledge that is present before a clock edge appears at the outputs right after that edge, so the block has one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_we | input | N_CORES | Per-core identity register write enable |
| id_wdata | input | TAG_W | Identity value to be written |
| snd_vld | input | N_CORES | Per-core send strobe |
| snd_msg | input | N_CORES*32 | Per-core send payload, core c at [c*32 +: 32] |
| clr_vld | input | N_CORES | Per-core clear strobe |
| clr_msg | input | N_CORES*32 | Per-core clear payload, only the kind field is used |
| ack_norm | input | N_CORES | Core took its normal doorbell |
| ack_crit | input | N_CORES | Core took its critical doorbell |
| pend_norm | output | N_CORES | Normal doorbell pending per core |
| pend_crit | output | N_CORES | Critical doorbell pending per core |
| irq | output | N_CORES | Interrupt request per core |

## Verification
The bench gives two cores the same identity, so a send must hit both of them. A design that stopped at the first matching core would leave the second one quiet. It sends broadcast guest kinds and clears with guest kinds, where a loose kind decode would set or drop bits. It also sends a tag that no core holds, which a broken tag compare would deliver anyway. Set-against-clear and set-against-acknowledge collisions check that the set wins, since the wrong order would lose a doorbell. A clear on one core checks that the bits of its neighbours and of the other kind stay as they were.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int MSG_W     = 32;
  localparam int KIND_HI   = 31;
  localparam int KIND_LO   = 27;
  localparam int KIND_W    = KIND_HI - KIND_LO + 1;
  localparam int BCAST_BIT = 26;

  typedef enum logic [KIND_W-1:0] {
    KIND_NORM  = 5'd0,
    KIND_CRIT  = 5'd1,
    KIND_GUEST = 5'd2,
    KIND_GCRIT = 5'd3,
    KIND_GMCHK = 5'd4
  } db_kind_e;

  typedef struct packed {
    logic norm;
    logic crit;
    logic bcast;
  } db_dec_t;

  function automatic logic [KIND_W-1:0] kind_of(input logic [MSG_W-1:0] msg);
    return msg[KIND_HI:KIND_LO];
  endfunction

  function automatic db_dec_t decode_msg(input logic [MSG_W-1:0] msg);
    db_dec_t d;
    d.norm  = (kind_of(msg) == KIND_NORM);
    d.crit  = (kind_of(msg) == KIND_CRIT);
    d.bcast = msg[BCAST_BIT];
    return d;
  endfunction

  // set dominates clear
  function automatic logic pend_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/db_id_regs.sv
module db_id_regs #(
  parameter int N_CORES = 4,
  parameter int TAG_W   = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CORES-1:0]       id_we,
  input  logic [TAG_W-1:0]         id_wdata,
  output logic [N_CORES*TAG_W-1:0] id_flat
);
  for (genvar c = 0; c < N_CORES; c++) begin : g_id
    logic [TAG_W-1:0] id_q;
    always_ff @(posedge clk) begin
      if (!rst_n)        id_q <= TAG_W'(c);
      else if (id_we[c]) id_q <= id_wdata;
    end
    assign id_flat[c*TAG_W +: TAG_W] = id_q;
  end
endmodule

// File: rtl/db_msg_decode.sv
module db_msg_decode #(
  parameter int TAG_W = 14
) (
  input  logic                     vld,
  input  logic [db_pkg::MSG_W-1:0] msg,
  output logic                     is_norm,
  output logic                     is_crit,
  output logic                     bcast,
  output logic [TAG_W-1:0]         tag
);
  import db_pkg::*;
  db_dec_t d;
  always_comb begin
    d       = decode_msg(msg);
    is_norm = vld & d.norm;
    is_crit = vld & d.crit;
    bcast   = d.bcast;
    tag     = msg[TAG_W-1:0];
  end
endmodule

// File: rtl/db_target_match.sv
module db_target_match #(
  parameter int N_CORES = 4,
  parameter int TAG_W   = 14
) (
  input  logic [N_CORES-1:0]       s_norm,
  input  logic [N_CORES-1:0]       s_crit,
  input  logic [N_CORES-1:0]       s_bcast,
  input  logic [N_CORES*TAG_W-1:0] s_tag,
  input  logic [N_CORES*TAG_W-1:0] id_flat,
  output logic [N_CORES-1:0]       norm_set,
  output logic [N_CORES-1:0]       crit_set
);
  function automatic logic hits(input logic bc, input logic [TAG_W-1:0] tag,
                                input logic [TAG_W-1:0] id);
    return bc | (tag == id);
  endfunction

  always_comb begin
    norm_set = '0;
    crit_set = '0;
    for (int c = 0; c < N_CORES; c++) begin
      for (int s = 0; s < N_CORES; s++) begin
        if (hits(s_bcast[s], s_tag[s*TAG_W +: TAG_W], id_flat[c*TAG_W +: TAG_W])) begin
          norm_set[c] = norm_set[c] | s_norm[s];
          crit_set[c] = crit_set[c] | s_crit[s];
        end
      end
    end
  end
endmodule

// File: rtl/db_pend_slot.sv
module db_pend_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic norm_set,
  input  logic crit_set,
  input  logic norm_clr,
  input  logic crit_clr,
  output logic pend_norm,
  output logic pend_crit,
  output logic irq
);
  import db_pkg::*;
  logic n_nx, c_nx;
  always_comb begin
    n_nx = pend_next(pend_norm, norm_set, norm_clr);
    c_nx = pend_next(pend_crit, crit_set, crit_clr);
  end
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_norm <= 1'b0;
      pend_crit <= 1'b0;
      irq       <= 1'b0;
    end else begin
      pend_norm <= n_nx;
      pend_crit <= c_nx;
      irq       <= n_nx | c_nx;
    end
  end
endmodule

// File: rtl/db_router.sv
module db_router #(
  parameter int N_CORES = 4,
  parameter int TAG_W   = 14
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [N_CORES-1:0]                  id_we,
  input  logic [TAG_W-1:0]                    id_wdata,
  input  logic [N_CORES-1:0]                  snd_vld,
  input  logic [N_CORES*db_pkg::MSG_W-1:0]    snd_msg,
  input  logic [N_CORES-1:0]                  clr_vld,
  input  logic [N_CORES*db_pkg::MSG_W-1:0]    clr_msg,
  input  logic [N_CORES-1:0]                  ack_norm,
  input  logic [N_CORES-1:0]                  ack_crit,
  output logic [N_CORES-1:0]                  pend_norm,
  output logic [N_CORES-1:0]                  pend_crit,
  output logic [N_CORES-1:0]                  irq
);
  import db_pkg::*;
  localparam int MW = MSG_W;

  logic [N_CORES*TAG_W-1:0] id_flat;
  logic [N_CORES*TAG_W-1:0] s_tag;
  logic [N_CORES-1:0] s_norm, s_crit, s_bcast;
  logic [N_CORES-1:0] norm_set, crit_set;
  logic [N_CORES-1:0] norm_clr, crit_clr;

  db_id_regs #(.N_CORES(N_CORES), .TAG_W(TAG_W)) u_ids (
    .clk(clk), .rst_n(rst_n), .id_we(id_we), .id_wdata(id_wdata), .id_flat(id_flat)
  );

  for (genvar s = 0; s < N_CORES; s++) begin : g_snd
    db_msg_decode #(.TAG_W(TAG_W)) u_dec (
      .vld(snd_vld[s]), .msg(snd_msg[s*MW +: MW]),
      .is_norm(s_norm[s]), .is_crit(s_crit[s]), .bcast(s_bcast[s]),
      .tag(s_tag[s*TAG_W +: TAG_W])
    );
  end

  db_target_match #(.N_CORES(N_CORES), .TAG_W(TAG_W)) u_match (
    .s_norm(s_norm), .s_crit(s_crit), .s_bcast(s_bcast), .s_tag(s_tag),
    .id_flat(id_flat), .norm_set(norm_set), .crit_set(crit_set)
  );

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    logic [TAG_W-1:0] unused_tag;
    logic c_norm, c_crit, c_bc;
    db_msg_decode #(.TAG_W(TAG_W)) u_cdec (
      .vld(clr_vld[c]), .msg(clr_msg[c*MW +: MW]),
      .is_norm(c_norm), .is_crit(c_crit), .bcast(c_bc), .tag(unused_tag)
    );
    assign norm_clr[c] = c_norm | ack_norm[c];
    assign crit_clr[c] = c_crit | ack_crit[c];

    db_pend_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .norm_set(norm_set[c]), .crit_set(crit_set[c]),
      .norm_clr(norm_clr[c]), .crit_clr(crit_clr[c]),
      .pend_norm(pend_norm[c]), .pend_crit(pend_crit[c]), .irq(irq[c])
    );
  end
endmodule

// File: rtl/db_router_chk.sv
module db_router_chk #(
  parameter int N_CORES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_CORES-1:0]   snd_vld,
  input logic [31:0]          snd_msg0,
  input logic [N_CORES-1:0]   norm_set,
  input logic [N_CORES-1:0]   crit_set,
  input logic [N_CORES-1:0]   norm_clr,
  input logic [N_CORES-1:0]   crit_clr,
  input logic [N_CORES-1:0]   pend_norm,
  input logic [N_CORES-1:0]   pend_crit,
  input logic [N_CORES-1:0]   irq
);
  // R5
  irq_tracks_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (pend_norm | pend_crit));

  // R7
  norm_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_set != '0) |=> ((pend_norm & $past(norm_set)) == $past(norm_set)));

  // R7
  crit_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_set != '0) |=> ((pend_crit & $past(crit_set)) == $past(crit_set)));

  // R6
  norm_clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((norm_clr & ~norm_set) != '0) |=> ((pend_norm & $past(norm_clr & ~norm_set)) == '0));

  // R6
  crit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_crit & ~$past(crit_set | crit_clr)) ==
              ($past(pend_crit) & ~$past(crit_set | crit_clr))));

  // R4
  bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_vld[0] && snd_msg0[26] && snd_msg0[31:27] == 5'd0) |-> (norm_set == '1));
endmodule

bind db_router db_router_chk #(.N_CORES(N_CORES)) u_db_chk (
  .clk(clk), .rst_n(rst_n), .snd_vld(snd_vld), .snd_msg0(snd_msg[31:0]),
  .norm_set(norm_set), .crit_set(crit_set), .norm_clr(norm_clr), .crit_clr(crit_clr),
  .pend_norm(pend_norm), .pend_crit(pend_crit), .irq(irq)
);

// File: tb/test_db_router.sv
`timescale 1ns/1ps
module test_db_router;
  localparam int N = 4;
  localparam int TW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] id_we = '0;
  logic [TW-1:0] id_wdata = '0;
  logic [N-1:0] snd_vld = '0, clr_vld = '0, ack_norm = '0, ack_crit = '0;
  logic [N*32-1:0] snd_msg = '0, clr_msg = '0;
  logic [N-1:0] pend_norm, pend_crit, irq;

  always #4 clk = ~clk;

  db_router #(.N_CORES(N), .TAG_W(TW)) i_db_router (
    .clk(clk), .rst_n(rst_n), .id_we(id_we), .id_wdata(id_wdata),
    .snd_vld(snd_vld), .snd_msg(snd_msg), .clr_vld(clr_vld), .clr_msg(clr_msg),
    .ack_norm(ack_norm), .ack_crit(ack_crit),
    .pend_norm(pend_norm), .pend_crit(pend_crit), .irq(irq)
  );

  typedef struct {
    logic [N-1:0] n;
    logic [N-1:0] c;
    string        req;
  } exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0;
  logic [TW-1:0] mid [N];
  logic [N-1:0] mn = '0, mc = '0;

  // stimulus staged for the next tick
  logic [N-1:0] st_sv, st_cv, st_an, st_ac, st_we;
  logic [31:0] st_sm [N];
  logic [31:0] st_cm [N];
  logic [TW-1:0] st_wd;

  function automatic logic [31:0] mk(input logic [4:0] k, input logic bc, input logic [13:0] t);
    return {k, bc, 12'h000, t};
  endfunction

  task automatic stage_clear();
    st_sv = '0; st_cv = '0; st_an = '0; st_ac = '0; st_we = '0; st_wd = '0;
    for (int i = 0; i < N; i++) begin st_sm[i] = '0; st_cm[i] = '0; end
  endtask

  task automatic tick(input string req);
    logic [N-1:0] sn, sc, cn, cc;
    exp_t e;
    @(negedge clk);
    snd_vld = st_sv; clr_vld = st_cv; ack_norm = st_an; ack_crit = st_ac;
    id_we = st_we; id_wdata = st_wd;
    for (int i = 0; i < N; i++) begin
      snd_msg[i*32 +: 32] = st_sm[i];
      clr_msg[i*32 +: 32] = st_cm[i];
    end
    sn = '0; sc = '0; cn = '0; cc = '0;
    for (int d = 0; d < N; d++) begin
      for (int s = 0; s < N; s++) begin
        if (st_sv[s] && (st_sm[s][26] || st_sm[s][13:0] == mid[d])) begin
          if (st_sm[s][31:27] == 5'd0) sn[d] = 1'b1;
          if (st_sm[s][31:27] == 5'd1) sc[d] = 1'b1;
        end
      end
      cn[d] = st_an[d] | (st_cv[d] && st_cm[d][31:27] == 5'd0);
      cc[d] = st_ac[d] | (st_cv[d] && st_cm[d][31:27] == 5'd1);
    end
    mn = sn | (mn & ~cn);
    mc = sc | (mc & ~cc);
    for (int d = 0; d < N; d++) if (st_we[d]) mid[d] = st_wd;
    e.n = mn; e.c = mc; e.req = req;
    sb.push_back(e);
    stage_clear();
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (pend_norm !== e.n || pend_crit !== e.c || irq !== (e.n | e.c)) begin
          fails++;
          $display("FAIL %s: norm=%b crit=%b irq=%b expected norm=%b crit=%b irq=%b",
                   e.req, pend_norm, pend_crit, irq, e.n, e.c, e.n | e.c);
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      fails++; checks++;
      $display("FAIL watchdog: cycles=%0d expected < 5000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) mid[i] = TW'(i);
    stage_clear();
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (pend_norm !== '0 || pend_crit !== '0 || irq !== '0) begin
      fails++;
      $display("FAIL R1: norm=%b crit=%b irq=%b expected 0000", pend_norm, pend_crit, irq);
    end
    @(negedge clk); rst_n = 1'b1;
    tick("R1 idle");
    // R9: default IDs equal the core index
    st_sv[3] = 1'b1; st_sm[3] = mk(5'd0, 1'b0, 14'd2); tick("R9 reset id R11");
    st_cv[2] = 1'b1; st_cm[2] = mk(5'd0, 1'b0, 14'd0); tick("R6 clear");
    // R9: reprogram IDs, core0 and core2 share an ID
    st_we = 4'b0001; st_wd = 14'h0011; tick("R9 write");
    st_we = 4'b0010; st_wd = 14'h2222; tick("R9 write");
    st_we = 4'b0100; st_wd = 14'h0011; tick("R9 write");
    st_we = 4'b1000; st_wd = 14'h3FFF; tick("R9 write");
    st_sv[1] = 1'b1; st_sm[1] = mk(5'd0, 1'b0, 14'h0011); tick("R3 dual match R5");
    st_sv[0] = 1'b1; st_sm[0] = mk(5'd1, 1'b0, 14'h1234); tick("R3 no match");
    st_sv[2] = 1'b1; st_sm[2] = mk(5'd1, 1'b1, 14'h0000); tick("R4 bcast crit");
    st_cv[2] = 1'b1; st_cm[2] = mk(5'd1, 1'b0, 14'h0000); tick("R6 clear crit own");
    st_sv = 4'b1111;
    st_sm[0] = mk(5'd2, 1'b1, 14'h0); st_sm[1] = mk(5'd3, 1'b1, 14'h0);
    st_sm[2] = mk(5'd4, 1'b1, 14'h0); st_sm[3] = mk(5'd7, 1'b1, 14'h3FFF);
    tick("R2 guest send");
    st_cv = 4'b1111;
    st_cm[0] = mk(5'd2, 1'b0, 14'h0); st_cm[1] = mk(5'd3, 1'b0, 14'h0);
    st_cm[2] = mk(5'd4, 1'b0, 14'h0); st_cm[3] = mk(5'd31, 1'b0, 14'h0);
    tick("R2 guest clear");
    st_an[0] = 1'b1; tick("R8 ack norm");
    st_ac[1] = 1'b1; tick("R8 ack crit");
    st_sv[0] = 1'b1; st_sm[0] = mk(5'd0, 1'b0, 14'h3FFF);
    st_cv[3] = 1'b1; st_cm[3] = mk(5'd0, 1'b0, 14'h0); tick("R7 set vs clear");
    st_sv[1] = 1'b1; st_sm[1] = mk(5'd1, 1'b0, 14'h3FFF);
    st_ac[3] = 1'b1; tick("R7 set vs ack");
    st_an = 4'b1111; st_ac = 4'b1111; tick("R8 ack all");
    st_sv = 4'b0011;
    st_sm[0] = mk(5'd0, 1'b0, 14'h2222); st_sm[1] = mk(5'd1, 1'b0, 14'h3FFF);
    tick("R10 multi sender");
    st_sv[3] = 1'b1; st_sm[3] = mk(5'd0, 1'b1, 14'h1555); tick("R4 bcast norm");
    tick("R11 hold");
    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule